// File: doc/BRIEF.md
# EEPROM Page Buffer and Write Sequencer

This block sits behind a two-wire serial slave engine and in front of a nonvolatile byte array. Once the engine has decoded a write command and its word address, it pulses a write-start event carrying that address. The block then takes each received data byte into a small page buffer. The slot for each byte comes from a 4-bit offset that steps inside the current page, while the upper address bits stay fixed. When more bytes arrive than the page holds, the offset wraps and the newer bytes replace the older ones in the slots they land on.

Nothing reaches the array until a STOP closes the write. On STOP, the block commits every slot that was filled during this transaction. It writes one byte per cycle, in ascending slot order, and raises a busy flag for a self-timed programming window whose length in clock cycles is a parameter. The engine uses the busy flag to withhold acknowledges. A START seen mid-transaction discards the buffer, so a repeated START never commits anything. A write-protect input suppresses every commit. A STOP with no data bytes only leaves the address pointer set.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, `busy_o` is 0, `mem_we_o` is 0 and `ptr_o` is 0.
- R2: A `wr_start_i` pulse while not busy loads `ptr_o` with `wr_addr_i` and discards any bytes buffered earlier in the transaction, including when it arrives mid-transaction.
- R3: Each accepted data byte goes to slot `ptr_o[3:0]`. Bits [3:0] of `ptr_o` then increment modulo 16, and the bits above bit 3 stay unchanged.
- R4: When more than 16 bytes arrive before STOP, a slot written twice commits the byte that arrived last.
- R5: The array is written only after `stop_i`. A `bus_start_i` pulse during a write transaction abandons it, and no write or busy period follows.
- R6: On STOP with at least one byte and `wp_i` low, each filled slot is written exactly once, at address {upper `ptr_o` bits, slot}. Writes go in ascending slot order, one per cycle, starting in the cycle after STOP. Slots not filled during the transaction are not written.
- R7: `busy_o` rises in the cycle after a committing STOP and stays high for exactly max(`WR_CYCLES`, 16) cycles.
- R8: While `busy_o` is high, `wr_start_i`, `data_valid_i`, `stop_i` and `bus_start_i` have no effect: `ptr_o` does not change and no extra write occurs.
- R9: With `wp_i` high at STOP, no write and no busy period occur, and `mem_we_o` is never high while `wp_i` is high.
- R10: A STOP with no data bytes starts no busy period and leaves `ptr_o` at the loaded address.
- R11: `data_valid_i` and `stop_i` outside a write transaction are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_start_i | input | 1 | Pulse: any START condition seen on the bus |
| wr_start_i | input | 1 | Pulse: write command and word address decoded |
| wr_addr_i | input | ADDR_W | Word address that goes with `wr_start_i` |
| data_valid_i | input | 1 | Pulse: a data byte was received |
| data_i | input | DATA_W | Received data byte |
| stop_i | input | 1 | Pulse: STOP condition seen |
| wp_i | input | 1 | Write protect, high blocks commits |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_wdata_o | output | DATA_W | Array write data |
| busy_o | output | 1 | Self-timed write period in progress |
| ptr_o | output | ADDR_W | Current address pointer |

## Verification
The hardest case to reach from the ports is input arriving inside the busy window. The engine would normally hold such traffic back, so only a deliberately misbehaving driver produces it. The bench injects a write start with a new address, a data byte, a STOP and a START at chosen cycles inside the window. It then checks that the pointer, the write count and the page contents are unchanged. Random transactions of 0 to 20 bytes at random offsets also exercise page wrap and partial masks. Directed sequences cover mid-transaction reloads, abandons and protected writes.

// File: rtl/eeprom_pw_pkg.sv
package eeprom_pw_pkg;

    typedef enum logic [1:0] {
        PW_IDLE = 2'd0,
        PW_FILL = 2'd1,
        PW_PROG = 2'd2
    } pw_state_e;

    typedef struct packed {
        logic load;
        logic abandon;
        logic put;
        logic commit;
        logic close;
    } pw_evt_t;

    // Index of the lowest set bit, 0 when none is set.
    function automatic int first_set(input logic [31:0] m);
        int r;
        r = 0;
        for (int i = 31; i >= 0; i--) begin
            if (m[i]) r = i;
        end
        return r;
    endfunction

    function automatic int hold_len(input int wr_cycles, input int page_bytes);
        return (wr_cycles < page_bytes) ? page_bytes : wr_cycles;
    endfunction

endpackage

// File: rtl/pw_page_buffer.sv
module pw_page_buffer #(
    parameter int PAGE_BYTES = 16,
    parameter int DATA_W     = 8,
    parameter int OFF_W      = $clog2(PAGE_BYTES)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  logic                  load,
    input  logic [OFF_W-1:0]      load_off,
    input  logic                  put,
    input  logic [DATA_W-1:0]     put_data,
    input  logic                  drain,
    input  logic [OFF_W-1:0]      drain_idx,
    output logic [OFF_W-1:0]      off_o,
    output logic [PAGE_BYTES-1:0] mask_o,
    output logic [DATA_W-1:0]     rd_data_o
);

    logic [DATA_W-1:0]     slot_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] valid_q;
    logic [OFF_W-1:0]      off_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            off_q <= '0;
        end else if (load) begin
            off_q <= load_off;
        end else if (put) begin
            off_q <= off_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        for (int s = 0; s < PAGE_BYTES; s++) begin
            if (put && off_q == OFF_W'(s)) slot_q[s] <= put_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else begin
            for (int s = 0; s < PAGE_BYTES; s++) begin
                if (clr) begin
                    valid_q[s] <= 1'b0;
                end else if (put && off_q == OFF_W'(s)) begin
                    valid_q[s] <= 1'b1;
                end else if (drain && drain_idx == OFF_W'(s)) begin
                    valid_q[s] <= 1'b0;
                end
            end
        end
    end

    assign off_o     = off_q;
    assign mask_o    = valid_q;
    assign rd_data_o = slot_q[drain_idx];

    // R6: a drained slot must have been filled
    a_r6_drain_filled: assert property (@(posedge clk) disable iff (rst)
        drain |-> valid_q[drain_idx]);

    // R2: clearing leaves no slot marked
    a_r2_clear_empties: assert property (@(posedge clk) disable iff (rst)
        clr |=> (valid_q == '0));

endmodule

// File: rtl/pw_commit_pick.sv
module pw_commit_pick
    import eeprom_pw_pkg::*;
#(
    parameter int PAGE_BYTES = 16,
    parameter int OFF_W      = $clog2(PAGE_BYTES)
) (
    input  logic [PAGE_BYTES-1:0] mask_i,
    output logic                  any_o,
    output logic [OFF_W-1:0]      idx_o
);

    assign any_o = |mask_i;
    assign idx_o = OFF_W'(first_set(32'(mask_i)));

endmodule

// File: rtl/pw_wr_timer.sv
module pw_wr_timer #(
    parameter int HOLD  = 16,
    parameter int CNT_W = $clog2(HOLD + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic kick,
    output logic run_o,
    output logic last_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (kick) begin
            run_q <= 1'b1;
            cnt_q <= CNT_W'(HOLD - 1);
        end else if (run_q) begin
            if (cnt_q == '0) begin
                run_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign run_o  = run_q;
    assign last_o = run_q && (cnt_q == '0);

    // R7: the window cannot end while count remains
    a_r7_hold_until_zero: assert property (@(posedge clk) disable iff (rst)
        (run_q && cnt_q != '0) |=> run_q);

    // R8: no restart inside a running window
    a_r8_no_rekick: assert property (@(posedge clk) disable iff (rst)
        kick |-> !run_q);

endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
    import eeprom_pw_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 16,
    parameter int WR_CYCLES  = 2000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_start_i,
    input  logic              wr_start_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic              data_valid_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              stop_i,
    input  logic              wp_i,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              busy_o,
    output logic [ADDR_W-1:0] ptr_o
);

    localparam int OFF_W  = $clog2(PAGE_BYTES);
    localparam int BASE_W = ADDR_W - OFF_W;
    localparam int HOLD   = hold_len(WR_CYCLES, PAGE_BYTES);

    pw_state_e             state_q, state_d;
    logic [BASE_W-1:0]     base_q;
    pw_evt_t               ev;
    logic                  in_fill, in_prog;
    logic [OFF_W-1:0]      off;
    logic [PAGE_BYTES-1:0] mask;
    logic [DATA_W-1:0]     rd_data;
    logic                  any_pend;
    logic [OFF_W-1:0]      pick_idx;
    logic                  drain, clr;
    logic                  t_run, t_last;

    assign in_fill = (state_q == PW_FILL);
    assign in_prog = (state_q == PW_PROG);

    always_comb begin
        ev         = '0;
        ev.close   = in_fill && stop_i;
        ev.commit  = ev.close && (|mask) && !wp_i;
        ev.load    = !in_prog && wr_start_i && !ev.close;
        ev.abandon = in_fill && bus_start_i && !stop_i && !wr_start_i;
        ev.put     = in_fill && data_valid_i && !stop_i && !wr_start_i && !bus_start_i;
    end

    assign drain = in_prog && any_pend && !wp_i;
    assign clr   = ev.load || ev.abandon || (ev.close && !ev.commit) || (in_prog && t_last);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PW_IDLE: if (ev.load) state_d = PW_FILL;
            PW_FILL: begin
                if (ev.commit)                  state_d = PW_PROG;
                else if (ev.close || ev.abandon) state_d = PW_IDLE;
            end
            PW_PROG: if (t_last) state_d = PW_IDLE;
            default: state_d = PW_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PW_IDLE;
            base_q  <= '0;
        end else begin
            state_q <= state_d;
            if (ev.load) base_q <= wr_addr_i[ADDR_W-1:OFF_W];
        end
    end

    pw_page_buffer #(
        .PAGE_BYTES (PAGE_BYTES),
        .DATA_W     (DATA_W),
        .OFF_W      (OFF_W)
    ) u_buf (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .load      (ev.load),
        .load_off  (wr_addr_i[OFF_W-1:0]),
        .put       (ev.put),
        .put_data  (data_i),
        .drain     (drain),
        .drain_idx (pick_idx),
        .off_o     (off),
        .mask_o    (mask),
        .rd_data_o (rd_data)
    );

    pw_commit_pick #(
        .PAGE_BYTES (PAGE_BYTES),
        .OFF_W      (OFF_W)
    ) u_pick (
        .mask_i (mask),
        .any_o  (any_pend),
        .idx_o  (pick_idx)
    );

    pw_wr_timer #(
        .HOLD (HOLD)
    ) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .kick   (ev.commit),
        .run_o  (t_run),
        .last_o (t_last)
    );

    assign mem_we_o    = drain;
    assign mem_addr_o  = {base_q, pick_idx};
    assign mem_wdata_o = rd_data;
    assign busy_o      = t_run;
    assign ptr_o       = {base_q, off};

    // R9: protected array never sees a strobe
    a_r9_no_write_when_protected: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |-> !wp_i);

    // R6: writes only inside the busy window
    a_r6_write_inside_busy: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |-> busy_o);

    // R6: the same address is never written in two consecutive cycles
    a_r6_slot_once: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |=> !(mem_we_o && mem_addr_o == $past(mem_addr_o)));

    // R5: a busy window only opens after STOP
    a_r5_busy_after_stop: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(stop_i));

    // R8: pointer frozen across the busy window
    a_r8_ptr_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(ptr_o));

    // R3: upper pointer bits fixed while bytes stream in
    a_r3_upper_fixed: assert property (@(posedge clk) disable iff (rst)
        (in_fill && data_valid_i && !wr_start_i) |=> $stable(ptr_o[ADDR_W-1:OFF_W]));

endmodule

// File: tb/tb_eeprom_page_writer.sv
module tb_eeprom_page_writer;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 10;
    localparam int DATA_W     = 8;
    localparam int PAGE       = 16;
    localparam int WR_CYC     = 40;
    localparam int MEM_N      = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_start = 1'b0, wr_start = 1'b0, dv = 1'b0, stop = 1'b0, wp = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] din = '0;
    logic              mem_we, busy;
    logic [ADDR_W-1:0] mem_addr, ptr;
    logic [DATA_W-1:0] mem_wdata;

    always #(CLK_PERIOD / 2) clk = ~clk;

    eeprom_page_writer #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W), .PAGE_BYTES (PAGE), .WR_CYCLES (WR_CYC)
    ) dut (
        .clk (clk), .rst (rst), .bus_start_i (bus_start), .wr_start_i (wr_start),
        .wr_addr_i (wr_addr), .data_valid_i (dv), .data_i (din), .stop_i (stop),
        .wp_i (wp), .mem_we_o (mem_we), .mem_addr_o (mem_addr), .mem_wdata_o (mem_wdata),
        .busy_o (busy), .ptr_o (ptr)
    );

    int n_chk = 0, n_bad = 0;
    int wr_cnt = 0, order_bad = 0, wp_viol = 0;
    logic [ADDR_W-1:0] last_a = '0;
    logic [DATA_W-1:0] act_mem [MEM_N];
    logic [DATA_W-1:0] exp_mem [MEM_N];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    always @(negedge clk) begin
        if (!rst && mem_we === 1'b1) begin
            if (wr_cnt > 0 && mem_addr <= last_a) order_bad++;
            last_a = mem_addr;
            act_mem[mem_addr] = mem_wdata;
            wr_cnt++;
            if (wp) wp_viol++;
        end
    end

    task automatic pulse_wstart(input int a);
        wr_addr  = ADDR_W'(a);
        wr_start = 1'b1;
        @(negedge clk);
        wr_start = 1'b0;
    endtask

    task automatic pulse_byte(input logic [7:0] d);
        din = d;
        dv  = 1'b1;
        @(negedge clk);
        dv  = 1'b0;
    endtask

    task automatic pulse_stop();
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
    endtask

    task automatic pulse_bstart();
        bus_start = 1'b1;
        @(negedge clk);
        bus_start = 1'b0;
    endtask

    function automatic int page_miscompares(input int base);
        int m;
        m = 0;
        for (int i = 0; i < PAGE; i++)
            if (act_mem[base * PAGE + i] !== exp_mem[base * PAGE + i]) m++;
        return m;
    endfunction

    // One full write transaction with bench-side model of the page buffer.
    task automatic do_txn(input int addr, input int n, input bit wpv, input bit intrude);
        logic [7:0] eb [PAGE];
        bit         em [PAGE];
        int base, off, cnt, bc, exp_ptr;
        bit commit;
        for (int i = 0; i < PAGE; i++) begin eb[i] = '0; em[i] = 0; end
        while (busy === 1'b1) @(negedge clk);
        wp   = wpv;
        base = addr / PAGE;
        off  = addr % PAGE;
        pulse_wstart(addr);
        chk(ptr == ADDR_W'(addr), "R2 pointer load", int'(ptr), addr);
        for (int k = 0; k < n; k++) begin
            logic [7:0] d;
            d = 8'($urandom);
            pulse_byte(d);
            eb[off] = d;
            em[off] = 1;
            off = (off + 1) % PAGE;
        end
        exp_ptr = base * PAGE + off;
        chk(ptr == ADDR_W'(exp_ptr), "R3 offset step", int'(ptr), exp_ptr);
        cnt = 0;
        for (int i = 0; i < PAGE; i++) if (em[i]) cnt++;
        commit    = (cnt > 0) && !wpv;
        wr_cnt    = 0;
        order_bad = 0;
        pulse_stop();
        if (commit) begin
            chk(busy === 1'b1, "R7 busy after stop", int'(busy), 1);
            chk(mem_we === 1'b1, "R6 first write next cycle", int'(mem_we), 1);
        end else if (wpv) begin
            chk(busy === 1'b0, "R9 no busy when protected", int'(busy), 0);
        end else begin
            chk(busy === 1'b0, "R10 no busy on empty write", int'(busy), 0);
        end
        bc = 0;
        while (busy === 1'b1 && bc < 10000) begin
            bc++;
            wr_addr   = ADDR_W'(addr ^ 10'h2A5);
            wr_start  = intrude && (bc == 2);
            dv        = intrude && (bc == 3);
            stop      = intrude && (bc == 4);
            bus_start = intrude && (bc == 5);
            @(negedge clk);
        end
        wr_start = 1'b0; dv = 1'b0; stop = 1'b0; bus_start = 1'b0;
        chk(bc == (commit ? WR_CYC : 0), "R7 busy length", bc, commit ? WR_CYC : 0);
        chk(wr_cnt == (commit ? cnt : 0), "R6 write count", wr_cnt, commit ? cnt : 0);
        chk(order_bad == 0, "R6 ascending order", order_bad, 0);
        chk(wp_viol == 0, "R9 strobe under protect", wp_viol, 0);
        if (commit)
            for (int i = 0; i < PAGE; i++) if (em[i]) exp_mem[base * PAGE + i] = eb[i];
        chk(page_miscompares(base) == 0, "R4 page contents", page_miscompares(base), 0);
        if (intrude)
            chk(ptr == ADDR_W'(exp_ptr), "R8 intrusion ignored", int'(ptr), exp_ptr);
        else
            chk(ptr == ADDR_W'(exp_ptr), "R10 pointer kept", int'(ptr), exp_ptr);
        wp = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < MEM_N; i++) begin act_mem[i] = '0; exp_mem[i] = '0; end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0, "R1 busy reset", int'(busy), 0);
        chk(mem_we === 1'b0, "R1 we reset", int'(mem_we), 0);
        chk(ptr === '0, "R1 ptr reset", int'(ptr), 0);

        // R11: stray byte and STOP outside a transaction
        wr_cnt = 0;
        pulse_byte(8'h5A);
        pulse_stop();
        @(negedge clk);
        chk(ptr == '0, "R11 stray byte ignored", int'(ptr), 0);
        chk(busy === 1'b0 && wr_cnt == 0, "R11 stray stop ignored", wr_cnt, 0);

        // Directed corner cases
        do_txn(10'h013, 1, 1'b0, 1'b0);   // R6 single byte
        do_txn(10'h07C, 20, 1'b0, 1'b0);  // R4 wrap past page end
        do_txn(10'h120, 0, 1'b0, 1'b0);   // R10 empty write
        do_txn(10'h230, 5, 1'b1, 1'b0);   // R9 protected
        do_txn(10'h305, 6, 1'b0, 1'b1);   // R8 intrusion during busy

        // R5: START mid-write abandons the buffer
        wr_cnt = 0;
        pulse_wstart(10'h040);
        pulse_byte(8'h11); pulse_byte(8'h22); pulse_byte(8'h33);
        pulse_bstart();
        pulse_stop();
        @(negedge clk);
        chk(busy === 1'b0, "R5 abandon no busy", int'(busy), 0);
        chk(wr_cnt == 0, "R5 abandon no write", wr_cnt, 0);
        chk(ptr == 10'h043, "R5 pointer after abandon", int'(ptr), 10'h043);

        // R2: reload mid-write drops earlier bytes
        pulse_wstart(10'h080);
        pulse_byte(8'hA1); pulse_byte(8'hA2);
        do_txn(10'h1F5, 3, 1'b0, 1'b0);
        chk(page_miscompares(10'h080 / PAGE) == 0, "R2 reload dropped bytes",
            page_miscompares(10'h080 / PAGE), 0);

        // Random transactions
        for (int t = 0; t < 30; t++) begin
            int a, n;
            bit w, x;
            a = int'($urandom % MEM_N);
            n = int'($urandom % 21);
            w = ($urandom % 10) == 0;
            x = ($urandom % 8) == 0;
            do_txn(a, n, w, x);
        end
        summary();
    end

endmodule